// File: doc/BRIEF.md
# Sliced VBI ancillary packet parser

This block watches a byte stream of video interface port ancillary data and picks out sliced vertical-blanking-interval packets. A packet counts only when an end-of-active-video code comes before it. Any number of idle bytes may follow that code. After them come a three-byte ancillary preamble, a data identifier, a service identifier, a word count and two internal identifier bytes. The block keeps the data identifier only when it marks the first field or the second field. It decodes the service from the secondary identifier and works out the video line from the first internal identifier plus a line offset that software programs. For closed-caption packets it also checks the parity of the first two payload bytes.

Payload bytes leave on a separate byte stream. The checksum and fill bytes that pad the payload region are consumed and never sent on. When a packet ends, a one-cycle done strobe presents the service type, the line number, the second-field flag and an error flag. These values stay on the outputs until the next strobe. Biphase decoding of VPS payload and checksum verification belong to other blocks.

Both streams use valid/ready handshakes. A byte is taken on the input when `in_valid` and `in_ready` are both high at a rising clock edge. A byte is taken on the output when `pay_valid` and `pay_ready` are both high. The block holds `in_ready` low only while the byte on offer is a payload byte and the output stream is stalled. The payload stream carries no storage: its data and valid follow the input in the same cycle, and its ready reaches back to `in_ready` through logic only. A producer that raises `in_valid` must keep the byte steady until it is taken.

Top module: `vbi_anc_parser`

## Requirements
- R1: An end-of-active-video code is the bytes 0xFF, 0x00, 0x00 taken in a row, followed by a status byte of 0xB0, 0xF0, 0x90 or 0xD0. Any other status byte does not arm the parser, and bytes taken while it is not armed produce no done strobe and no payload.
- R2: Once armed, the parser skips any number of idle bytes until it sees the preamble 0x00, 0xFF, 0xFF. The byte that follows the preamble is taken as the data identifier.
- R3: A data identifier of 0x91 marks a first-field packet and 0x55 marks a second-field packet. Any other value ends the packet at once with a done strobe that reports type 0, line 0, second-field flag 0 and error 0. After such a rejection, nothing is forwarded until a new end-of-active-video code arrives.
- R4: The service type is bits [3:0] of the byte after the data identifier. Codes 1 (teletext), 4 (wide-screen signalling), 6 (closed caption) and 9 (VPS) are valid. Any other code sets the error flag.
- R5: The reported line is bits [5:0] of the byte after the word count, plus `line_offset`, given as a 7-bit sum with no wrap.
- R6: The word count is bits [5:0] of the byte after the service identifier, and the top two bits are ignored. The two internal identifier bytes are followed by a region of 4 × count bytes. The first count bytes of that region are forwarded on the payload stream in order. The checksum and fill bytes after them are consumed without `pay_valid`.
- R7: For service 6, both of the first two payload bytes must have odd parity. If either does not, or the count is below 2, the error flag is set.
- R8: When the error flag is reported, the type, line and second-field flag are all reported as 0.
- R9: An end-of-active-video code that completes in the middle of a packet drops that packet without a done strobe, and the parser starts looking for a preamble again. The byte that completes the code is never forwarded.
- R10: `res_done` is high for exactly one cycle. It rises in the cycle after the last byte of a packet is taken: the last region byte, or the second internal identifier byte when the count is 0, or a rejected data identifier. The result outputs hold their values until the next strobe.
- R11: `in_ready` is low only while a payload byte is on offer and `pay_ready` is low. `pay_valid` is high only while `in_valid` is high, so no payload byte is lost or duplicated.
- R12: After reset, `res_done`, the result outputs and `pay_valid` are 0, `in_ready` is 1, and the parser waits for an end-of-active-video code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_offset | input | OFS_W | Value added to the line number in the packet |
| in_valid | input | 1 | Input byte on offer |
| in_ready | output | 1 | Parser takes the offered byte |
| in_data | input | 8 | Ancillary stream byte |
| pay_valid | output | 1 | Payload byte on offer |
| pay_ready | input | 1 | Downstream takes the payload byte |
| pay_data | output | 8 | Payload byte |
| res_done | output | 1 | One-cycle strobe: packet finished, results valid |
| res_type | output | 4 | Service code, or 0 |
| res_line | output | LINE_W | Corrected line number, or 0 |
| res_field2 | output | 1 | Packet belongs to the second field |
| res_err | output | 1 | Service or parity check failed |

## Verification
Payload handshakes are combinational. `pay_valid`, `pay_data` and `in_ready` must match the byte on offer within the same cycle, so the bench compares them with its model one time unit after each falling edge, after that cycle's inputs have settled. Results are due one clock later. The model marks the final byte of each packet when that byte is taken at a rising edge, and it expects `res_done` together with the result fields at the next mid-cycle sample. At every other sample it requires `res_done` to be low. This catches a strobe that is early, late, repeated or missing.

// File: rtl/vbi_anc_pkg.sv
package vbi_anc_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_PRE,
    ST_DID,
    ST_SDID,
    ST_WC,
    ST_ID0,
    ST_ID1,
    ST_REG
  } pstate_e;

  localparam logic [7:0]  DID_FIELD1 = 8'h91;
  localparam logic [7:0]  DID_FIELD2 = 8'h55;
  localparam logic [23:0] EAV_LEAD   = 24'hFF0000;

  localparam logic [3:0] SVC_TTX = 4'd1;
  localparam logic [3:0] SVC_WSS = 4'd4;
  localparam logic [3:0] SVC_CC  = 4'd6;
  localparam logic [3:0] SVC_VPS = 4'd9;

endpackage

// File: rtl/vbi_eav_detect.sv
// Flags the status byte that completes an end-of-active-video code.
// match_o depends only on the taken history and the byte on offer.
module vbi_eav_detect
  import vbi_anc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] byte_i,
  input  logic       take_i,
  output logic       match_o
);
  logic [23:0] hist_q;
  logic        status_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else if (take_i) hist_q <= {hist_q[15:0], byte_i};
  end

  assign status_ok = (byte_i == 8'hB0) || (byte_i == 8'hF0) ||
                     (byte_i == 8'h90) || (byte_i == 8'hD0);
  assign match_o = (hist_q == EAV_LEAD) && status_ok;
endmodule

// File: rtl/vbi_svc_check.sv
// Decides whether a finished packet is in error, from its service code
// and the result of the caption parity check.
module vbi_svc_check
  import vbi_anc_pkg::*;
(
  input  logic [3:0] svc_i,
  input  logic       cc_ok_i,
  output logic       err_o
);
  logic known;

  always_comb begin
    known = (svc_i == SVC_TTX) || (svc_i == SVC_WSS) ||
            (svc_i == SVC_CC)  || (svc_i == SVC_VPS);
    err_o = !known || ((svc_i == SVC_CC) && !cc_ok_i);
  end
endmodule

// File: rtl/vbi_anc_parser.sv
module vbi_anc_parser
  import vbi_anc_pkg::*;
#(
  parameter  int OFS_W  = 6,
  parameter  int WC_W   = 6,
  localparam int ID_W   = 6,
  localparam int LINE_W = ((OFS_W > ID_W) ? OFS_W : ID_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFS_W-1:0]  line_offset,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              pay_valid,
  input  logic              pay_ready,
  output logic [7:0]        pay_data,
  output logic              res_done,
  output logic [3:0]        res_type,
  output logic [LINE_W-1:0] res_line,
  output logic              res_field2,
  output logic              res_err
);
  localparam int CNT_W = WC_W + 2;

  pstate_e           state_q;
  logic [1:0]        pre_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WC_W-1:0]   wc_q;
  logic [3:0]        svc_q;
  logic              f2_q;
  logic [LINE_W-1:0] line_q;
  logic [1:0]        par_q;

  logic eav_match, take, eav_hit, fwd, region_last;
  logic cc_ok, svc_err, did_ok, finish, reject;

  vbi_eav_detect u_eav (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_i  (in_data),
    .take_i  (take),
    .match_o (eav_match)
  );

  // Payload forwarding window: the first wc bytes of the region.
  assign fwd         = (state_q == ST_REG) && (cnt_q < {2'b00, wc_q});
  assign in_ready    = fwd ? (pay_ready | eav_match) : 1'b1;
  assign take        = in_valid & in_ready;
  assign eav_hit     = take & eav_match;
  assign pay_valid   = in_valid & fwd & ~eav_match;
  assign pay_data    = in_data;
  assign region_last = (cnt_q == ({wc_q, 2'b00} - CNT_W'(1)));
  assign did_ok      = (in_data == DID_FIELD1) || (in_data == DID_FIELD2);

  // Parity is known only once the region has been entered.
  assign cc_ok = (state_q == ST_REG) && (par_q == 2'b11);

  vbi_svc_check u_svc (
    .svc_i   (svc_q),
    .cc_ok_i (cc_ok),
    .err_o   (svc_err)
  );

  assign finish = take & ~eav_match &
                  (((state_q == ST_ID1) && (wc_q == '0)) ||
                   ((state_q == ST_REG) && region_last));
  assign reject = take & ~eav_match & (state_q == ST_DID) & ~did_ok;

  // Header and region sequencing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      pre_q   <= '0;
      cnt_q   <= '0;
      wc_q    <= '0;
      svc_q   <= '0;
      f2_q    <= 1'b0;
      line_q  <= '0;
      par_q   <= '0;
    end else if (eav_hit) begin
      state_q <= ST_PRE;
      pre_q   <= '0;
    end else if (take) begin
      unique case (state_q)
        ST_HUNT: ;
        ST_PRE: begin
          if (in_data == 8'h00) pre_q <= 2'd1;
          else if (in_data == 8'hFF && pre_q == 2'd1) pre_q <= 2'd2;
          else if (in_data == 8'hFF && pre_q == 2'd2) begin
            pre_q   <= '0;
            state_q <= ST_DID;
          end else pre_q <= '0;
        end
        ST_DID: begin
          f2_q    <= (in_data == DID_FIELD2);
          state_q <= did_ok ? ST_SDID : ST_HUNT;
        end
        ST_SDID: begin
          svc_q   <= in_data[3:0];
          state_q <= ST_WC;
        end
        ST_WC: begin
          wc_q    <= in_data[WC_W-1:0];
          state_q <= ST_ID0;
        end
        ST_ID0: begin
          line_q  <= LINE_W'(in_data[ID_W-1:0]) + LINE_W'(line_offset);
          state_q <= ST_ID1;
        end
        ST_ID1: begin
          par_q   <= '0;
          cnt_q   <= '0;
          state_q <= (wc_q == '0) ? ST_HUNT : ST_REG;
        end
        ST_REG: begin
          if (fwd && cnt_q == CNT_W'(0)) par_q[0] <= ^in_data;
          if (fwd && cnt_q == CNT_W'(1)) par_q[1] <= ^in_data;
          cnt_q <= cnt_q + CNT_W'(1);
          if (region_last) state_q <= ST_HUNT;
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  // Result registers, updated only with the done strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_done   <= 1'b0;
      res_type   <= '0;
      res_line   <= '0;
      res_field2 <= 1'b0;
      res_err    <= 1'b0;
    end else begin
      res_done <= finish | reject;
      if (reject) begin
        res_type   <= '0;
        res_line   <= '0;
        res_field2 <= 1'b0;
        res_err    <= 1'b0;
      end else if (finish) begin
        res_err    <= svc_err;
        res_type   <= svc_err ? 4'd0 : svc_q;
        res_line   <= svc_err ? '0 : line_q;
        res_field2 <= svc_err ? 1'b0 : f2_q;
      end
    end
  end
endmodule

// File: rtl/vbi_anc_parser_chk.sv
module vbi_anc_parser_chk #(
  parameter int LINE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              pay_valid,
  input logic              pay_ready,
  input logic              res_done,
  input logic [3:0]        res_type,
  input logic [LINE_W-1:0] res_line,
  input logic              res_field2,
  input logic              res_err
);
  a_r8_err_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    res_done && res_err |-> res_type == 4'd0 && res_line == '0 && !res_field2);

  a_r4_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> res_type inside {4'd0, 4'd1, 4'd4, 4'd6, 4'd9});

  a_r3_reject_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_done && res_type == 4'd0 |-> res_line == '0 && !res_field2);

  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_done |-> $stable(res_type) && $stable(res_line) &&
                  $stable(res_field2) && $stable(res_err));

  a_r11_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid && !pay_ready |-> !in_ready);

  a_r11_valid_src: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> in_valid);

  a_r11_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready |-> pay_valid && !pay_ready);
endmodule

bind vbi_anc_parser vbi_anc_parser_chk #(.LINE_W(LINE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .pay_valid  (pay_valid),
  .pay_ready  (pay_ready),
  .res_done   (res_done),
  .res_type   (res_type),
  .res_line   (res_line),
  .res_field2 (res_field2),
  .res_err    (res_err)
);

// File: tb/vbi_anc_parser_tb.sv
`timescale 1ns/1ps
module vbi_anc_parser_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] line_offset = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       pay_valid;
  logic       pay_ready = 1'b1;
  logic [7:0] pay_data;
  logic       res_done;
  logic [3:0] res_type;
  logic [6:0] res_line;
  logic       res_field2;
  logic       res_err;

  always #2 clk = ~clk;

  vbi_anc_parser u_dut (
    .clk(clk), .rst_n(rst_n), .line_offset(line_offset),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .res_done(res_done), .res_type(res_type), .res_line(res_line),
    .res_field2(res_field2), .res_err(res_err)
  );

  int    checks = 0;
  int    errors = 0;
  bit    mon_on = 0;
  bit    rdy_s = 0;
  bit    cur_pay = 0;
  bit    cur_last = 0;
  bit    due = 0;
  bit    bp_on = 0;
  bit    finished = 0;
  string phase_req = "R12";
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] q_b[$];
  bit         q_p[$];
  bit         q_l[$];
  logic [7:0] pay_q[$];
  int e_type[$], e_line[$], e_f2[$], e_err[$];

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Downstream ready pattern, changed only at falling edges.
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pay_ready = bp_on ? lfsr[0] : 1'b1;
  end

  // Reference comparison in the middle of every cycle.
  always @(negedge clk) begin
    #1;
    rdy_s = in_ready;
    if (mon_on) begin
      if (in_valid) begin
        check(in_ready == (cur_pay ? pay_ready : 1'b1), "R11 in_ready",
              int'(in_ready), int'(cur_pay ? pay_ready : 1'b1));
        check(pay_valid == cur_pay, {phase_req, " R6 pay_valid"},
              int'(pay_valid), int'(cur_pay));
      end else begin
        check(pay_valid == 1'b0, "R11 pay_valid idle", int'(pay_valid), 0);
      end
      if (pay_valid && pay_ready) begin
        if (pay_q.size() == 0) check(0, "R6 unexpected payload", int'(pay_data), -1);
        else begin
          logic [7:0] eb;
          eb = pay_q.pop_front();
          check(pay_data == eb, "R6 payload byte", int'(pay_data), int'(eb));
        end
      end
      check(res_done == due, {phase_req, " R10 done timing"}, int'(res_done), int'(due));
      if (due && res_done) begin
        if (e_type.size() == 0) check(0, "R10 no expected result", 0, -1);
        else begin
          int t, l, f, e;
          t = e_type.pop_front(); l = e_line.pop_front();
          f = e_f2.pop_front();   e = e_err.pop_front();
          check(int'(res_type) == t, {phase_req, " type"}, int'(res_type), t);
          check(int'(res_line) == l, {phase_req, " line"}, int'(res_line), l);
          check(int'(res_field2) == f, {phase_req, " field2"}, int'(res_field2), f);
          check(int'(res_err) == e, {phase_req, " err"}, int'(res_err), e);
        end
      end
      due = 0;
    end
  end

  task automatic push(input logic [7:0] b, input bit p, input bit l);
    q_b.push_back(b); q_p.push_back(p); q_l.push_back(l);
    if (p) pay_q.push_back(b);
  endtask

  task automatic play();
    while (q_b.size() > 0) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = q_b.pop_front();
      cur_pay  = q_p.pop_front();
      cur_last = q_l.pop_front();
      @(posedge clk);
      while (!rdy_s) @(posedge clk);
      if (cur_last) due = 1;
    end
    @(negedge clk);
    in_valid = 1'b0; cur_pay = 0; cur_last = 0;
  endtask

  task automatic pkt(input logic [7:0] st, input int idle, input logic [7:0] did,
                     input logic [7:0] sdid, input logic [7:0] wcb, input logic [7:0] id0,
                     input logic [7:0] p0, input logic [7:0] p1, input int abort_at);
    int wc, reg_n;
    bit ok, er;
    logic [3:0] svc;
    wc = int'(wcb[5:0]);
    reg_n = 4 * wc;
    push(8'hFF, 0, 0); push(8'h00, 0, 0); push(8'h00, 0, 0); push(st, 0, 0);
    for (int k = 0; k < idle; k++) push(8'h10 + 8'(k), 0, 0);
    push(8'h00, 0, 0); push(8'hFF, 0, 0); push(8'hFF, 0, 0);
    if (did != 8'h91 && did != 8'h55) begin
      push(did, 0, 1);
      e_type.push_back(0); e_line.push_back(0); e_f2.push_back(0); e_err.push_back(0);
      play();
      return;
    end
    push(did, 0, 0); push(sdid, 0, 0); push(wcb, 0, 0); push(id0, 0, 0);
    push(8'h80, 0, (wc == 0) && (abort_at < 0));
    for (int i = 0; i < reg_n; i++) begin
      logic [7:0] b;
      if (i == abort_at) begin
        push(8'hFF, i < wc, 0); push(8'h00, i + 1 < wc, 0);
        push(8'h00, i + 2 < wc, 0); push(8'hB0, 0, 0);
        break;
      end
      b = (i == 0) ? p0 : (i == 1) ? p1 :
          (i < wc) ? ((8'(i * 29 + 7) & 8'h7F) | 8'h01) : 8'hA5;
      push(b, i < wc, i == reg_n - 1);
    end
    if (abort_at < 0) begin
      svc = sdid[3:0];
      ok  = (svc == 1) || (svc == 4) || (svc == 6) || (svc == 9);
      er  = !ok || (svc == 6 && (wc < 2 || !(^p0) || !(^p1)));
      if (er) begin
        e_type.push_back(0); e_line.push_back(0); e_f2.push_back(0); e_err.push_back(1);
      end else begin
        e_type.push_back(int'(svc));
        e_line.push_back(int'(id0[5:0]) + int'(line_offset));
        e_f2.push_back(did == 8'h55 ? 1 : 0);
        e_err.push_back(0);
      end
    end
    play();
  endtask

  task automatic raw(input logic [7:0] b);
    push(b, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R10 watchdog expired: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12: state right after reset.
    check(res_done == 0 && res_type == 0 && res_line == 0 && !res_field2 && !res_err,
          "R12 reset results", int'(res_done), 0);
    check(in_ready == 1'b1, "R12 reset in_ready", int'(in_ready), 1);
    check(pay_valid == 1'b0, "R12 reset pay_valid", int'(pay_valid), 0);
    mon_on = 1;

    // R1: a wrong status byte does not arm the parser.
    phase_req = "R1";
    raw(8'hFF); raw(8'h00); raw(8'h00); raw(8'h80);
    raw(8'h00); raw(8'hFF); raw(8'hFF); raw(8'h91); raw(8'h06); raw(8'h01);
    raw(8'h05); raw(8'h80); raw(8'h01); raw(8'h07); raw(8'h33); raw(8'h44);
    play();

    // R2 R4 R5 R6: teletext, idle bytes, parity bits on the count.
    phase_req = "R2";
    pkt(8'hB0, 3, 8'h91, 8'h21, 8'hC3, 8'hC7, 8'h5A, 8'h3C, -1);

    // R3 R5: second field, wide-screen signalling, offset added.
    phase_req = "R3";
    line_offset = 6'd5;
    pkt(8'hF0, 0, 8'h55, 8'h04, 8'h02, 8'd23, 8'h12, 8'h34, -1);

    // R7: caption with good parity.
    phase_req = "R7";
    pkt(8'h90, 1, 8'h91, 8'h06, 8'h02, 8'd21, 8'h01, 8'h07, -1);
    // R7 R8: bad parity on the second byte.
    phase_req = "R8";
    pkt(8'h90, 0, 8'h55, 8'h06, 8'h02, 8'd21, 8'h01, 8'h03, -1);
    // R7: count too short for the parity check.
    phase_req = "R7";
    pkt(8'hD0, 0, 8'h91, 8'h06, 8'h01, 8'd21, 8'h01, 8'h07, -1);

    // R6 R11: VPS with back-pressure on the payload stream.
    phase_req = "R11";
    bp_on = 1;
    pkt(8'hD0, 2, 8'h91, 8'h09, 8'h0D, 8'd16, 8'hAB, 8'hCD, -1);

    // R4 R8: unknown service on a second-field packet.
    phase_req = "R4";
    pkt(8'hB0, 0, 8'h55, 8'h05, 8'h01, 8'd9, 8'h11, 8'h22, -1);

    // R3: rejected identifier, then garbage that must be ignored.
    phase_req = "R3";
    pkt(8'hB0, 0, 8'h92, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, -1);
    raw(8'h00); raw(8'hFF); raw(8'hFF); raw(8'h91); raw(8'h01); raw(8'h01);
    raw(8'h02); raw(8'h80); raw(8'h77); raw(8'h66); raw(8'h55); raw(8'h44);
    play();

    // R10: zero count ends on the second internal identifier byte.
    phase_req = "R10";
    pkt(8'hF0, 0, 8'h91, 8'h01, 8'h40, 8'd12, 8'h00, 8'h00, -1);

    // R9: a code inside the payload drops the packet; the next one is clean.
    phase_req = "R9";
    pkt(8'hB0, 0, 8'h91, 8'h01, 8'h0A, 8'd14, 8'h21, 8'h43, 3);
    pkt(8'h90, 2, 8'h55, 8'h09, 8'h03, 8'd18, 8'h99, 8'h88, -1);

    // R5: largest line plus largest offset.
    phase_req = "R5";
    bp_on = 0;
    line_offset = 6'd63;
    pkt(8'hB0, 0, 8'h91, 8'h04, 8'h01, 8'h3F, 8'h0F, 8'h00, -1);

    repeat (4) @(negedge clk);
    check(pay_q.size() == 0, "R6 payload all delivered", pay_q.size(), 0);
    check(e_type.size() == 0, "R10 all results seen", e_type.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule